// File: doc/BRIEF.md
# RAM Signature Calculator

This block checks the integrity of a RAM array in the background while the array serves as microcode store for one or more microengines. While emulation mode is active and the scan enable is set, it reads the array from the highest address down to address zero. It compresses each word into a 32-bit signature held in a parallel-input linear feedback register. It never competes with the microengines. It issues a read only in a cycle where no microengine is making a back-to-back request, so fetch timing is left untouched.

At the end of each pass the finished signature is copied into a result register that software can read. A one-cycle done pulse marks the update, and a new pass starts at once from the top address. If the enable is cleared or emulation mode ends partway through a pass, the partial result is thrown away and the next pass begins again at the top.

Top module: `sig_ram_scan`

## Requirements
- R1: While reset is asserted and after its release, rd_en, sig_done and sig_valid are low and sig_value is zero.
- R2: rd_en is low in every cycle where scan_en or emu_active is low.
- R3: rd_en is high exactly in the cycles where scan_en and emu_active are both high and no bit of ue_b2b is set.
- R4: Within a pass the reads target addresses 2^ADDR_W-1, 2^ADDR_W-2, ... down to 0, one lower per read. The read after address 0 targets 2^ADDR_W-1 again.
- R5: The signature starts each pass at 0xFFFFFFFF. The RAM returns rd_data one cycle after rd_en. Each returned word is zero-extended to 32 bits (data in the low bits) and folded in as S' = ({S[30:0],0} XOR (S[31] ? 0x04C11DB7 : 0)) XOR word.
- R6: When the word from address 0 is folded in, sig_value takes the final signature and sig_done is high for exactly that one cycle, one clock after the data cycle. sig_valid is then high.
- R7: If scan_en or emu_active goes low during a pass, the pass is discarded. sig_value keeps its old value, sig_valid drops, and the next read after re-activation targets the top address.
- R8: sig_value changes only in a cycle where sig_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| scan_en | input | 1 | Signature scan enable |
| emu_active | input | 1 | Emulation mode is active |
| ue_b2b | input | NUM_UE | Per-microengine back-to-back request flags |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | ADDR_W | RAM read address |
| rd_data | input | WORD_W | RAM read data, valid the cycle after rd_en |
| sig_value | output | 32 | Signature of the last completed pass |
| sig_done | output | 1 | One-cycle pulse when sig_value is updated |
| sig_valid | output | 1 | A pass has completed since activation |

## Verification
The scan is run with no microengine traffic, with each engine busy about half the time, and with both busy most of the time. Only the spacing between reads changes across these runs, so a correct design gives the same signature in each. A signature that differs points to a slot, ordering or pipeline fault. Array contents of all zeros, all ones and random words separate the preset, the feedback taps and the zero-extension from each other. Aborts through the enable, through the emulation flag, and in the exact cycle the last word is pending show whether partial passes leak into the result or the address restart.

// File: rtl/sigcalc_pkg.sv
package sigcalc_pkg;

  localparam int SIG_W = 32;

  typedef logic [SIG_W-1:0] sig_t;

  localparam sig_t SIG_POLY = 32'h04C1_1DB7;
  localparam sig_t SIG_SEED = '1;

  // One Galois shift with feedback, then absorb the parallel input word.
  function automatic sig_t misr_step(input sig_t state, input sig_t word);
    sig_t shifted;
    shifted = {state[SIG_W-2:0], 1'b0};
    if (state[SIG_W-1]) begin
      shifted = shifted ^ SIG_POLY;
    end
    return shifted ^ word;
  endfunction

endpackage

// File: rtl/sig_slot_arb.sv
module sig_slot_arb #(
  parameter int NUM_UE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NUM_UE-1:0] ue_b2b,
  output logic              grant
);

  logic [NUM_UE:0] busy_chain;

  // Busy reduction built as an OR chain across the microengines.
  assign busy_chain[0] = 1'b0;
  generate
    for (genvar g = 0; g < NUM_UE; g++) begin : g_busy
      assign busy_chain[g+1] = busy_chain[g] | ue_b2b[g];
    end
  endgenerate

  assign grant = run & ~busy_chain[NUM_UE];

  AST_NO_STEAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_b2b != '0) |-> !grant);  // R3

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !grant);  // R2

endmodule

// File: rtl/sig_addr_seq.sv
module sig_addr_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              grant,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              at_bottom
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = !run || grant;
    addr_d  = addr_q;
    if (!run) begin
      addr_d = ADDR_TOP;
    end else if (grant) begin
      addr_d = addr_q - 1'b1;  // wraps from zero back to the top
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= ADDR_TOP;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign rd_addr   = addr_q;
  assign at_bottom = (addr_q == '0);

  AST_ADDR_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !at_bottom) |=> (!run || rd_addr == $past(rd_addr) - 1'b1));  // R4

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && at_bottom) |=> (rd_addr == ADDR_TOP));  // R4

  AST_RESTART_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> (rd_addr == ADDR_TOP));  // R7

endmodule

// File: rtl/sig_misr.sv
module sig_misr
  import sigcalc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              issue,
  input  logic              issue_last,
  input  logic [WORD_W-1:0] rd_data,
  output sig_t              sig_value,
  output logic              sig_done,
  output logic              sig_valid
);

  sig_t word_ext;

  generate
    if (WORD_W < SIG_W) begin : g_zext
      assign word_ext = {{(SIG_W-WORD_W){1'b0}}, rd_data};
    end else begin : g_trunc
      assign word_ext = rd_data[SIG_W-1:0];
    end
  endgenerate

  logic pend_q, pend_d;
  logic last_q, last_d, last_en;
  sig_t acc_q, acc_d, acc_step;
  sig_t res_q, res_d;
  logic res_en;
  logic done_q, done_d;
  logic valid_q, valid_d;
  logic fold;

  always_comb begin
    fold     = run && pend_q;
    acc_step = misr_step(acc_q, word_ext);
    pend_d   = run && issue;
    last_en  = issue;
    last_d   = issue_last;
    acc_d    = acc_q;
    if (!run) begin
      acc_d = SIG_SEED;
    end else if (fold) begin
      acc_d = last_q ? SIG_SEED : acc_step;
    end
    done_d  = fold && last_q;
    res_en  = done_d;
    res_d   = acc_step;
    valid_d = run && (valid_q || done_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      last_q  <= 1'b0;
      acc_q   <= SIG_SEED;
      res_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      if (last_en) begin
        last_q <= last_d;
      end
      acc_q   <= acc_d;
      if (res_en) begin
        res_q <= res_d;
      end
      done_q  <= done_d;
      valid_q <= valid_d;
    end
  end

  assign sig_value = res_q;
  assign sig_done  = done_q;
  assign sig_valid = valid_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sig_done |=> !sig_done);  // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    sig_done |-> $past(issue && issue_last, 2));  // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_done |-> $stable(sig_value));  // R8

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> !sig_valid);  // R7

endmodule

// File: rtl/sig_ram_scan.sv
module sig_ram_scan
  import sigcalc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int NUM_UE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              emu_active,
  input  logic [NUM_UE-1:0] ue_b2b,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [31:0]       sig_value,
  output logic              sig_done,
  output logic              sig_valid
);

  logic rst_meta_q;
  logic rst_sync_n;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic run;
  logic grant;
  logic at_bottom;
  sig_t sig_word;

  assign run = scan_en && emu_active;

  sig_slot_arb #(
    .NUM_UE(NUM_UE)
  ) u_arb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .ue_b2b(ue_b2b),
    .grant (grant)
  );

  sig_addr_seq #(
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .grant    (grant),
    .rd_addr  (rd_addr),
    .at_bottom(at_bottom)
  );

  sig_misr #(
    .WORD_W(WORD_W)
  ) u_misr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run),
    .issue     (grant),
    .issue_last(at_bottom),
    .rd_data   (rd_data),
    .sig_value (sig_word),
    .sig_done  (sig_done),
    .sig_valid (sig_valid)
  );

  assign rd_en     = grant;
  assign sig_value = sig_word;

  AST_READ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |-> (scan_en && emu_active));  // R2

endmodule

// File: tb/sig_ram_scan_tb.sv
module sig_ram_scan_tb;

  localparam int ADDR_W = 6;
  localparam int WORD_W = 16;
  localparam int NUM_UE = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam int WATCHDOG_NS = 400000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              scan_en;
  logic              emu_active;
  logic [NUM_UE-1:0] ue_b2b;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic [31:0]       sig_value;
  logic              sig_done;
  logic              sig_valid;

  always #2 clk = ~clk;  // 250 MHz

  sig_ram_scan #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_UE(NUM_UE)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .emu_active(emu_active),
    .ue_b2b(ue_b2b), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sig_value(sig_value), .sig_done(sig_done), .sig_valid(sig_valid)
  );

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Bench-side model state
  logic [ADDR_W-1:0] exp_addr = TOP;
  bit    fresh = 1;
  bit    pend0 = 0;
  bit    d_exp = 0;
  bit    v_exp = 0;
  bit    run_prev = 0;
  logic [31:0] sv_prev = '0;
  int    done_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_step(input logic [31:0] s, input logic [31:0] w);
    logic [31:0] t;
    t = {s[30:0], 1'b0};
    if (s[31]) t = t ^ 32'h04C1_1DB7;
    return t ^ w;
  endfunction

  function automatic logic [31:0] golden();
    logic [31:0] s;
    s = 32'hFFFF_FFFF;
    for (int a = DEPTH - 1; a >= 0; a--) s = ref_step(s, {16'h0000, mem[a]});
    return s;
  endfunction

  task automatic step(input bit en, input bit emu, input int busy_pct);
    bit d_now;
    bit run;
    @(posedge clk);
    #1;
    d_now = d_exp;
    v_exp = run_prev ? (v_exp | d_now) : 1'b0;
    chk(sig_done === d_now, "R6", "sig_done", {31'd0, sig_done}, {31'd0, d_now});
    chk(sig_valid === v_exp, run_prev ? "R6" : "R7", "sig_valid",
        {31'd0, sig_valid}, {31'd0, v_exp});
    if (d_now) begin
      chk(sig_value === golden(), "R5", "signature", sig_value, golden());
      done_cnt++;
    end else begin
      chk(sig_value === sv_prev, "R8", "sig_value hold", sig_value, sv_prev);
    end
    sv_prev = sig_value;
    scan_en    = en;
    emu_active = emu;
    for (int i = 0; i < NUM_UE; i++) ue_b2b[i] = ($urandom_range(99) < busy_pct);
    #1;
    run = en && emu;
    if (!run) begin
      chk(rd_en === 1'b0, "R2", "rd_en inactive", {31'd0, rd_en}, 32'd0);
    end else begin
      chk(rd_en === (ue_b2b == '0), "R3", "rd_en slot", {31'd0, rd_en},
          {31'd0, (ue_b2b == '0)});
    end
    d_exp = pend0 && run;
    pend0 = rd_en && (rd_addr == '0);
    if (run && rd_en) begin
      chk(rd_addr === exp_addr, fresh ? "R7" : "R4", "rd_addr",
          {26'd0, rd_addr}, {26'd0, exp_addr});
      exp_addr = exp_addr - 1'b1;
      fresh = 0;
    end
    if (!run) begin
      exp_addr = TOP;
      fresh = 1;
    end
    run_prev = run;
  endtask

  task automatic run_passes(input int n, input int busy_pct);
    int target;
    int guard;
    target = done_cnt + n;
    guard = 0;
    while (done_cnt < target && guard < 20000) begin
      step(1, 1, busy_pct);
      guard++;
    end
    chk(done_cnt == target, "R6", "passes completed", done_cnt, target);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 1, 0);
  endtask

  initial begin : watchdog
    #(WATCHDOG_NS);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4561));
    for (int a = 0; a < DEPTH; a++) mem[a] = 16'($urandom);
    rst_n = 1'b0;
    scan_en = 1'b0;
    emu_active = 1'b0;
    ue_b2b = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(rd_en === 1'b0, "R1", "rd_en reset", {31'd0, rd_en}, 32'd0);
    chk(sig_done === 1'b0, "R1", "sig_done reset", {31'd0, sig_done}, 32'd0);
    chk(sig_valid === 1'b0, "R1", "sig_valid reset", {31'd0, sig_valid}, 32'd0);
    chk(sig_value === 32'd0, "R1", "sig_value reset", sig_value, 32'd0);
    rst_n = 1'b1;
    idle(4);
    chk(sig_value === 32'd0 && sig_valid === 1'b0, "R1", "after release",
        sig_value, 32'd0);

    // R2: enable alone or emulation alone must not read
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 1, 0);

    // R4/R5: no traffic, two back-to-back passes
    run_passes(2, 0);
    // R3: moderate and heavy microengine traffic
    run_passes(1, 50);
    run_passes(1, 90);

    // R5: all-zero and all-ones contents
    idle(3);
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    run_passes(1, 30);
    idle(3);
    for (int a = 0; a < DEPTH; a++) mem[a] = '1;
    run_passes(1, 30);

    // R7: abort via enable midway
    idle(3);
    for (int a = 0; a < DEPTH; a++) mem[a] = 16'($urandom);
    for (int i = 0; i < 20; i++) step(1, 1, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    run_passes(1, 20);
    // R7: abort via emulation exit midway
    for (int i = 0; i < 40; i++) step(1, 1, 10);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    run_passes(1, 20);
    // R7: abort in the cycle the last word is pending
    idle(2);
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    chk(sig_valid === 1'b0, "R7", "no result from aborted last word",
        {31'd0, sig_valid}, 32'd0);
    run_passes(1, 0);

    // Random stress: occasional mode drops, random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(99) >= 2), ($urandom_range(99) >= 1),
           $urandom_range(95));
    end
    idle(3);
    run_passes(1, 40);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule